// File: doc/BRIEF.md
# Video Field Identifier Generator

This block keeps a one-bit field flag for an incoming video stream and decodes it into odd and even indications for the capture logic downstream. The flag can come from one of four sources, chosen by a two-bit mode input:

- the field bit carried by each valid embedded header;
- a flag that inverts every time the start of the capture window is detected;
- the level of the horizontal reference, sampled at a chosen edge of the vertical reference;
- none, in which case the flag holds.

Each source updates the flag only at its own event. A force-zero control overrides every source.

A swap control sets how the flag maps to odd and even. It acts on the decoded outputs combinationally, so a change of swap shows at once and does not wait for any field event. The flag is the only state in the block besides a one-cycle delay of the vertical reference, which is used to detect its edges. All inputs are taken as synchronous to `clk`.

Top module: `fid_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `field_flag` is 0.
- R2: With `mode` = 2'b00 (header) and `hdr_valid` high at a clock edge, `field_flag` takes the value of `hdr_field` in the following cycle.
- R3: With `mode` = 2'b01 (toggle) and `win_start` high at a clock edge, `field_flag` inverts in the following cycle.
- R4: With `mode` = 2'b10 (reference) and `vref_rise_sel` = 0, a falling edge of `vref` loads the current `href` level into `field_flag`. A falling edge is `vref` low at a clock edge after it was high at the previous clock edge.
- R5: With `mode` = 2'b10 and `vref_rise_sel` = 1, only a rising edge of `vref` (low at the previous edge, high now) loads `href` into `field_flag`.
- R6: `force_zero` high at a clock edge makes `field_flag` 0 in the following cycle. This takes priority over every update event.
- R7: `is_odd` is high exactly when `field_flag` equals `swap`, and `is_even` is its complement. Both follow `swap` in the same cycle.
- R8: An event that belongs to a mode other than the selected one leaves `field_flag` unchanged. After a change of mode, the flag holds its value until the first event of the new mode.
- R9: With `mode` = 2'b11, `field_flag` holds regardless of `hdr_valid`, `win_start`, `href` and `vref`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Flag source: 00 header, 01 toggle, 10 reference, 11 hold |
| force_zero | input | 1 | Holds the flag at 0 |
| vref_rise_sel | input | 1 | 1 selects the rising `vref` edge, 0 the falling one |
| swap | input | 1 | Reverses the flag-to-field mapping |
| href | input | 1 | Horizontal reference level |
| vref | input | 1 | Vertical reference level |
| hdr_valid | input | 1 | Pulse marking a valid embedded header |
| hdr_field | input | 1 | Field bit of that header |
| win_start | input | 1 | Pulse marking detected capture-window start |
| field_flag | output | 1 | Registered field flag |
| is_odd | output | 1 | Decoded odd field |
| is_even | output | 1 | Decoded even field |

## Verification
The force-zero control and the update event of the selected mode can arrive in the same clock cycle, and force-zero must win. The sweep sets up this collision by presenting every combination of `force_zero`, `hdr_valid`, `win_start`, `href`, the previous and current `vref` levels, edge select, swap and starting flag together in one cycle, for all four modes. The flag one cycle later is compared with a value worked out from the priority order. In the cycle before that edge, the decoded outputs are compared with the current swap value, which shows that a swap change in that same cycle acts at once.

// File: rtl/fid_gen.sv
module fid_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       force_zero,
  input  logic       vref_rise_sel,
  input  logic       swap,
  input  logic       href,
  input  logic       vref,
  input  logic       hdr_valid,
  input  logic       hdr_field,
  input  logic       win_start,
  output logic       field_flag,
  output logic       is_odd,
  output logic       is_even
);
  localparam logic [1:0] M_HDR = 2'b00;
  localparam logic [1:0] M_TGL = 2'b01;
  localparam logic [1:0] M_REF = 2'b10;

  logic vref_d;
  logic vref_evt;
  logic flag_nxt;

  assign vref_evt = vref_rise_sel ? (vref & ~vref_d) : (~vref & vref_d);

  always_comb begin
    flag_nxt = field_flag;
    if (force_zero)                        flag_nxt = 1'b0;
    else if (mode == M_HDR && hdr_valid)   flag_nxt = hdr_field;
    else if (mode == M_TGL && win_start)   flag_nxt = ~field_flag;
    else if (mode == M_REF && vref_evt)    flag_nxt = href;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vref_d     <= 1'b0;
      field_flag <= 1'b0;
    end else begin
      vref_d     <= vref;
      field_flag <= flag_nxt;
    end
  end

  assign is_odd  = ~(field_flag ^ swap);
  assign is_even = ~is_odd;
endmodule

// File: rtl/fid_gen_chk.sv
module fid_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       force_zero,
  input logic       vref_rise_sel,
  input logic       swap,
  input logic       href,
  input logic       vref,
  input logic       hdr_valid,
  input logic       hdr_field,
  input logic       win_start,
  input logic       field_flag,
  input logic       is_odd,
  input logic       is_even
);
  logic vprev;
  logic fall, rise, any_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) vprev <= 1'b0;
    else        vprev <= vref;
  end

  assign fall = vprev && !vref;
  assign rise = !vprev && vref;
  assign any_evt = force_zero
                || (mode == 2'b00 && hdr_valid)
                || (mode == 2'b01 && win_start)
                || (mode == 2'b10 && (vref_rise_sel ? rise : fall));

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> !field_flag); // R1
  AST_HDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_zero && mode == 2'b00 && hdr_valid) |=> field_flag == $past(hdr_field)); // R2
  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_zero && mode == 2'b01 && win_start) |=> field_flag != $past(field_flag)); // R3
  AST_REF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_zero && mode == 2'b10 && !vref_rise_sel && fall) |=> field_flag == $past(href)); // R4
  AST_REF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_zero && mode == 2'b10 && vref_rise_sel && rise) |=> field_flag == $past(href)); // R5
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    force_zero |=> !field_flag); // R6
  AST_NO_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> $stable(field_flag)); // R8

  always_comb begin
    if (rst_n) begin
      AST_DECODE: assert (is_odd == (field_flag == swap) && is_even == !is_odd); // R7
    end
  end
endmodule

bind fid_gen fid_gen_chk u_fid_gen_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .force_zero(force_zero),
  .vref_rise_sel(vref_rise_sel), .swap(swap), .href(href), .vref(vref),
  .hdr_valid(hdr_valid), .hdr_field(hdr_field), .win_start(win_start),
  .field_flag(field_flag), .is_odd(is_odd), .is_even(is_even)
);

// File: tb/test_fid_gen.sv
`timescale 1ns/1ps
module test_fid_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic force_zero = 1'b0, vref_rise_sel = 1'b0, swap = 1'b0;
  logic href = 1'b0, vref = 1'b0, hdr_valid = 1'b0, hdr_field = 1'b0, win_start = 1'b0;
  logic field_flag, is_odd, is_even;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fid_gen i_fid_gen (
    .clk(clk), .rst_n(rst_n), .mode(mode), .force_zero(force_zero),
    .vref_rise_sel(vref_rise_sel), .swap(swap), .href(href), .vref(vref),
    .hdr_valid(hdr_valid), .hdr_field(hdr_field), .win_start(win_start),
    .field_flag(field_flag), .is_odd(is_odd), .is_even(is_even)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", field_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", field_flag, 1'b0);
    for (int idx = 0; idx < 4096; idx++) begin
      logic [1:0] m;
      logic fz, hv, hf, ws, hr, vp, vc, sel, sw, st, ev, exp;
      string tag;
      m = idx[1:0]; fz = idx[2]; hv = idx[3]; hf = idx[4]; ws = idx[5];
      hr = idx[6]; vp = idx[7]; vc = idx[8]; sel = idx[9]; sw = idx[10]; st = idx[11];
      mode = 2'b00; force_zero = 1'b0; hdr_valid = 1'b1; hdr_field = st;
      win_start = 1'b0; vref = vp; href = 1'b0; vref_rise_sel = sel; swap = 1'b0;
      @(negedge clk);
      mode = m; force_zero = fz; hdr_valid = hv; hdr_field = hf; win_start = ws;
      href = hr; vref = vc; swap = sw;
      #1;
      check("R7 decode odd", is_odd, (st == sw));
      check("R7 decode even", is_even, (st != sw));
      ev = sel ? (!vp && vc) : (vp && !vc);
      exp = st;
      if (fz) begin exp = 1'b0; tag = "R6 force zero"; end
      else if (m == 2'b00) begin exp = hv ? hf : st; tag = hv ? "R2 header" : "R8 header idle"; end
      else if (m == 2'b01) begin exp = ws ? ~st : st; tag = ws ? "R3 toggle" : "R8 toggle idle"; end
      else if (m == 2'b10) begin
        exp = ev ? hr : st;
        tag = !ev ? "R8 reference idle" : (sel ? "R5 rising edge" : "R4 falling edge");
      end
      else tag = "R9 hold mode";
      @(negedge clk);
      check(tag, field_flag, exp);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule